// File: doc/BRIEF.md
# Broadcast Pin Configuration Writer

This block is the write-only register front end of a 32-pin I/O port that lets software reconfigure many pins with one bus write. A single full-word write carries a half-select bit, a 16-bit pin mask, one set of electrical settings and one 4-bit peripheral-multiplexer code. Every masked pin in the chosen half receives those values in the same clock cycle. Two independent enable bits in the written word decide whether the electrical settings, the multiplexer code, both or neither are applied.

The block holds the per-pin configuration registers and the multiplexer fields itself and presents them on flat read ports for the pad logic. Partial-width writes do nothing, so a configuration is never applied partially. Non-secure accesses can change only pins that are marked non-secured. A write-protect input blocks writes and reports each blocked attempt. Reading the register always returns zero.

Top module: `pin_cfg_broadcast`

## Requirements
- R1: After reset every pin configuration and every multiplexer field is zero. `bus_rdata` reads 0x00000000 at all times.
- R2: A write is accepted only when `bus_addr` equals 0x28 and `bus_be` is 4'b1111. Any narrower strobe pattern or other address leaves all state unchanged.
- R3: Write bit 31 selects the half of the port: 0 targets pins 0 to 15 and 1 targets pins 16 to 31. Pins in the other half never change.
- R4: Write bits 15:0 form the pin mask. Bit k selects pin k of the chosen half, and a clear bit leaves that pin unchanged.
- R5: When write bit 30 is 1, each selected pin's 7-bit configuration takes write bits 22:16, packed as {drive(22), slew[1:0](21:20), open-drain(19), pull-enable(18), input-enable(17), mux-enable(16)}. When bit 30 is 0, no configuration changes.
- R6: When write bit 28 is 1, each selected pin's 4-bit multiplexer field takes write bits 27:24. When bit 28 is 0, no multiplexer field changes.
- R7: The two enables act independently, so one write can update configuration only, multiplexing only, both, or neither.
- R8: On a write with `bus_nonsec` high, a selected pin changes only if its bit in `pin_nonsec` is 1. Secure pins keep their state.
- R9: Multiplexer fields are stored two per byte, even pin in the low nibble and odd pin in the high nibble. Updating one pin leaves its neighbour's nibble intact.
- R10: Write bits 29 and 23 are ignored.
- R11: While `wr_protect` is high, a write to 0x28 of any width changes nothing, and `prot_err` goes high for exactly the next cycle.
- R12: An accepted write takes effect on its own clock edge, so the new values appear on `pin_cfg` and `pin_mux` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_be | input | 4 | Byte strobes of the write |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | Access is non-secure |
| bus_rdata | output | 32 | Read data, always zero |
| pin_nonsec | input | 32 | Per-pin non-secured attribute |
| wr_protect | input | 1 | Write protection active |
| prot_err | output | 1 | One-cycle pulse for a blocked write |
| pin_cfg | output | 224 | Pin i configuration at [7i+6:7i] |
| pin_mux | output | 128 | Pin i multiplexer code at [4i+3:4i] |

## Verification
A table of writes drives the fan-out with a lower-half mask using configuration only, an upper-half mask using multiplexing only, a single odd pin with both enables, and a full mask with neither enable. Comparing the outcomes separates the two enables from each other and from the half-select. A write with the reserved bits set and a partial-strobe write show whether anything outside the defined fields leaks into state. A non-secure write with an alternating attribute pattern covers the filtering. The single odd-pin write also shows that the even neighbour's nibble survives. Directed tests add a wrong address, write protection with its pulse width, the read value, a check that the effect lands one cycle later, and a mid-run reset.

// File: rtl/pinbc_pkg.sv
package pinbc_pkg;
  localparam int CFG_W      = 7;
  localparam int CFG_LSB    = 16;
  localparam int MUX_W      = 4;
  localparam int MUX_LSB    = 24;
  localparam int MASK_W     = 16;
  localparam int HALF_BIT   = 31;
  localparam int CFG_EN_BIT = 30;
  localparam int MUX_EN_BIT = 28;

  typedef struct packed {
    logic       drive;
    logic [1:0] slew;
    logic       odrain;
    logic       pull_en;
    logic       in_en;
    logic       mux_en;
  } pin_cfg_t;
endpackage

// File: rtl/pinbc_decode.sv
module pinbc_decode
  import pinbc_pkg::*;
#(
  parameter int PINS    = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_nonsec,
  input  logic [PINS-1:0]   pin_nonsec,
  input  logic              wr_protect,
  output logic [PINS-1:0]   cfg_we,
  output logic [PINS-1:0]   mux_we,
  output pin_cfg_t          cfg_val,
  output logic [MUX_W-1:0]  mux_val,
  output logic              prot_err
);
  localparam int HALF = PINS / 2;

  logic            hit, accept;
  logic [PINS-1:0] sel;
  logic            unused_rsvd;

  assign hit    = bus_wr && (bus_addr == REG_OFS);
  assign accept = hit && (&bus_be) && !wr_protect;

  for (genvar i = 0; i < PINS; i++) begin : g_sel
    localparam logic UPPER = (i >= HALF);
    assign sel[i] = bus_wdata[i % HALF] && (bus_wdata[HALF_BIT] == UPPER)
                    && (!bus_nonsec || pin_nonsec[i]);
  end

  assign cfg_we  = sel & {PINS{accept && bus_wdata[CFG_EN_BIT]}};
  assign mux_we  = sel & {PINS{accept && bus_wdata[MUX_EN_BIT]}};
  assign cfg_val = pin_cfg_t'(bus_wdata[CFG_LSB +: CFG_W]);
  assign mux_val = bus_wdata[MUX_LSB +: MUX_W];
  assign unused_rsvd = ^{bus_wdata[29], bus_wdata[23]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_err <= 1'b0;
    else        prot_err <= hit && wr_protect;
  end
endmodule

// File: rtl/pinbc_cfg_bank.sv
module pinbc_cfg_bank
  import pinbc_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PINS-1:0]       we,
  input  pin_cfg_t              val,
  output logic [PINS*CFG_W-1:0] cfg_flat
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_cfg_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[i]) q <= val;
    end
    assign cfg_flat[i*CFG_W +: CFG_W] = q;
  end
endmodule

// File: rtl/pinbc_mux_bank.sv
module pinbc_mux_bank
  import pinbc_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PINS-1:0]       we,
  input  logic [MUX_W-1:0]      val,
  output logic [PINS*MUX_W-1:0] mux_flat
);
  localparam int PAIRS = PINS / 2;

  for (genvar b = 0; b < PAIRS; b++) begin : g_pair
    logic [2*MUX_W-1:0] pair_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_q <= '0;
      else begin
        if (we[2*b])   pair_q[MUX_W-1:0]       <= val;
        if (we[2*b+1]) pair_q[2*MUX_W-1:MUX_W] <= val;
      end
    end
    assign mux_flat[2*b*MUX_W +: 2*MUX_W] = pair_q;
  end
endmodule

// File: rtl/pin_cfg_broadcast.sv
module pin_cfg_broadcast
  import pinbc_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_nonsec,
  output logic [31:0]           bus_rdata,
  input  logic [PINS-1:0]       pin_nonsec,
  input  logic                  wr_protect,
  output logic                  prot_err,
  output logic [PINS*CFG_W-1:0] pin_cfg,
  output logic [PINS*MUX_W-1:0] pin_mux
);
  logic [PINS-1:0]  cfg_we, mux_we;
  pin_cfg_t         cfg_val;
  logic [MUX_W-1:0] mux_val;

  assign bus_rdata = '0;

  pinbc_decode #(.PINS(PINS), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec),
    .pin_nonsec(pin_nonsec), .wr_protect(wr_protect),
    .cfg_we(cfg_we), .mux_we(mux_we), .cfg_val(cfg_val), .mux_val(mux_val),
    .prot_err(prot_err)
  );

  pinbc_cfg_bank #(.PINS(PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .val(cfg_val), .cfg_flat(pin_cfg)
  );

  pinbc_mux_bank #(.PINS(PINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .we(mux_we), .val(mux_val), .mux_flat(pin_mux)
  );
endmodule

// File: rtl/pin_cfg_broadcast_chk.sv
module pin_cfg_broadcast_chk
  import pinbc_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h28
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [3:0]            bus_be,
  input logic [31:0]           bus_wdata,
  input logic                  bus_nonsec,
  input logic [31:0]           bus_rdata,
  input logic [PINS-1:0]       pin_nonsec,
  input logic                  wr_protect,
  input logic                  prot_err,
  input logic [PINS*CFG_W-1:0] pin_cfg,
  input logic [PINS*MUX_W-1:0] pin_mux
);
  localparam int HALF = PINS / 2;
  logic hit, good;
  assign hit  = bus_wr && (bus_addr == REG_OFS);
  assign good = hit && (bus_be == 4'hF) && !wr_protect;

  // R2
  partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be != 4'hF) |=> ($stable(pin_cfg) && $stable(pin_mux)));

  // R3
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_wdata[HALF_BIT]) |=>
      ($stable(pin_cfg[PINS*CFG_W-1:HALF*CFG_W]) && $stable(pin_mux[PINS*MUX_W-1:HALF*MUX_W])));

  // R5
  cfg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_wdata[CFG_EN_BIT]) |=> $stable(pin_cfg));

  // R6
  mux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_wdata[MUX_EN_BIT]) |=> $stable(pin_mux));

  // R11
  prot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_protect) |=> (prot_err && $stable(pin_cfg) && $stable(pin_mux)));

  // R11
  prot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && wr_protect) |=> !prot_err);

  // R12
  pin0_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && bus_wdata[CFG_EN_BIT] && !bus_wdata[HALF_BIT] && bus_wdata[0]
     && (!bus_nonsec || pin_nonsec[0]))
    |=> (pin_cfg[CFG_W-1:0] == $past(bus_wdata[CFG_LSB +: CFG_W])));

  for (genvar i = 0; i < PINS; i++) begin : g_sec
    // R8
    secure_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_nonsec && !pin_nonsec[i]) |=>
        ($stable(pin_cfg[i*CFG_W +: CFG_W]) && $stable(pin_mux[i*MUX_W +: MUX_W])));
  end
endmodule

bind pin_cfg_broadcast pin_cfg_broadcast_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (.*);

// File: tb/pin_cfg_broadcast_tb.sv
module pin_cfg_broadcast_tb;
  localparam int PINS = 32;
  localparam int CW = 7;
  localparam int MW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_nonsec = 0, wr_protect = 0;
  logic [7:0] bus_addr = 8'h28;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_nonsec = '0;
  logic prot_err;
  logic [PINS*CW-1:0] pin_cfg;
  logic [PINS*MW-1:0] pin_mux;

  int n_chk = 0, n_bad = 0;
  logic [CW-1:0] ec [PINS];
  logic [MW-1:0] em [PINS];

  always #4ns clk = ~clk;

  pin_cfg_broadcast u_dut (.*);

  typedef struct packed {
    logic [31:0] wd;
    logic [3:0]  be;
    logic        ns;
    logic [31:0] attr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h407F_0005, 4'hF, 1'b0, 32'h0},         // R5 R4: cfg only, pins 0 and 2
    '{32'h9A00_00F0, 4'hF, 1'b0, 32'h0},         // R6 R3: mux only, pins 20..23
    '{32'h5325_0002, 4'hF, 1'b0, 32'h0},         // R7 R9: both, odd pin 1
    '{32'h0F7F_FFFF, 4'hF, 1'b0, 32'h0},         // R7: neither enable
    '{32'h6091_0100, 4'hF, 1'b0, 32'h0},         // R10: reserved bits set
    '{32'h5F7F_FFFF, 4'h3, 1'b0, 32'h0},         // R2: half-word strobe
    '{32'h5C2A_FFFF, 4'hF, 1'b1, 32'h0000_5555}  // R8: non-secure, even pins open
  };

  function automatic string vname(int i);
    case (i)
      0: return "R5";  1: return "R6";  2: return "R9";  3: return "R7";
      4: return "R10"; 5: return "R2";  default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [31:0] wd, input logic [3:0] be, input logic [7:0] a,
                       input logic ns, input logic [31:0] attr, input logic prot);
    if (a != 8'h28 || be != 4'hF || prot) return;
    for (int p = 0; p < PINS; p++) begin
      if (wd[31] == (p >= 16) && wd[p % 16] && (!ns || attr[p])) begin
        if (wd[30]) ec[p] = wd[22:16];
        if (wd[28]) em[p] = wd[27:24];
      end
    end
  endtask

  task automatic cmp_state(input string tag);
    int bad_pin = -1;
    for (int p = 0; p < PINS; p++)
      if (bad_pin < 0 && (pin_cfg[p*CW +: CW] != ec[p] || pin_mux[p*MW +: MW] != em[p]))
        bad_pin = p;
    n_chk++;
    if (bad_pin >= 0) begin
      n_bad++;
      $display("FAIL %s pin %0d cfg=%h mux=%h expected cfg=%h mux=%h", tag, bad_pin,
               pin_cfg[bad_pin*CW +: CW], pin_mux[bad_pin*MW +: MW], ec[bad_pin], em[bad_pin]);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] wd, input logic [3:0] be, input logic [7:0] a,
                          input logic ns, input logic [31:0] attr);
    @(negedge clk);
    bus_wr = 1; bus_wdata = wd; bus_be = be; bus_addr = a; bus_nonsec = ns; pin_nonsec = attr;
    model(wd, be, a, ns, attr, wr_protect);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic clear_model();
    for (int p = 0; p < PINS; p++) begin ec[p] = '0; em[p] = '0; end
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp_state("R1");
    chk_bit("R1 rdata", bus_rdata == 32'h0, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk_bit("R11 prot_err idle", prot_err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].wd, VECS[i].be, 8'h28, VECS[i].ns, VECS[i].attr);
      cmp_state(vname(i));
    end

    // R2: wrong address ignored
    do_write(32'h5F7F_FFFF, 4'hF, 8'h2C, 1'b0, 32'h0);
    cmp_state("R2 addr");

    // R1: read data is zero after state is populated
    chk_bit("R1 rdata busy", bus_rdata == 32'h0, 1'b1);

    // R11: protect blocks and pulses once
    @(negedge clk);
    wr_protect = 1; bus_wr = 1; bus_wdata = 32'hDF7F_FFFF; bus_be = 4'hF; bus_addr = 8'h28;
    bus_nonsec = 0;
    @(negedge clk);
    bus_wr = 0;
    chk_bit("R11 pulse", prot_err, 1'b1);
    cmp_state("R11 state");
    @(negedge clk);
    chk_bit("R11 one cycle", prot_err, 1'b0);
    wr_protect = 0;

    // R12: not visible before the edge, visible after it
    @(negedge clk);
    bus_wr = 1; bus_wdata = 32'hC07F_8000; bus_be = 4'hF; bus_addr = 8'h28; bus_nonsec = 0;
    #1ns;
    chk_bit("R12 before edge", pin_cfg[31*CW +: CW] == 7'h7F, ec[31] == 7'h7F);
    model(32'hC07F_8000, 4'hF, 8'h28, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    bus_wr = 0;
    cmp_state("R12 after edge");

    // R3: upper-half mux write must not reach lower pins
    do_write(32'h9700_0001, 4'hF, 8'h28, 1'b0, 32'h0);
    cmp_state("R3 upper pin16");

    // R1: reset mid-run clears all state
    @(negedge clk);
    rst_n = 0;
    clear_model();
    @(negedge clk);
    cmp_state("R1 rerst");
    rst_n = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule